// File: doc/BRIEF.md
# Button Combination Hold Detector

This block watches a small group of active-low button and key inputs and reports when a chosen set of them has been held low together for a chosen time. It has four independent channels that read the same inputs. Each channel has its own selection mask, its own hold threshold counted in clock ticks, and its own action mask. When a channel's hold time is reached it can do any of four things: set a sticky interrupt-status bit, start an active-low reset pulse for an external controller, send a one-cycle request for a local system reset, or send a one-cycle request to disconnect the battery.

A channel starts timing only when its selected inputs change from not-all-low to all-low. Releasing any selected input before the threshold is reached abandons the attempt. A channel that has fired stays quiet until its combination is released and pressed again. The width of the reset pulse is one shared programmable value. All settings arrive as plain inputs. Software clears a status bit by strobing the matching clear input.

Top module: `combo_hold_det`

## Requirements
- R1: Input bit 0 is the power button and bits 1 to 3 are keys 0 to 2, all active low. A channel's combination counts as pressed when every input whose selection bit is 1 is at 0. Inputs whose selection bit is 0 have no effect.
- R2: Timing starts only on a clock edge where the combination is pressed and was not pressed at the edge before. Inputs that are already pressed when reset is released do not start timing until they have been released.
- R3: With threshold H, a channel fires at the H-th clock edge after the edge that first sees the combination pressed. H=0 acts like H=1. If the combination is released before that, the attempt is dropped, and a new press restarts the count from zero.
- R4: A channel fires at most once for each press. Holding the combination after it has fired causes no further firing.
- R5: Action bit 0 (interrupt) makes the firing edge set the channel's status bit. The bit then stays set.
- R6: A high on statusClr[i] clears status bit i at the next edge. If the same channel fires on that edge, the bit is set.
- R7: irq is high exactly when at least one status bit is set.
- R8: Action bit 1 (reset pulse) makes ecRstN go low from the firing edge for exactly pulseWidth cycles. A width of 0 produces no pulse. A new firing during a pulse restarts the pulse at full width. After reset, ecRstN is high.
- R9: Action bit 2 makes sysRstReq high, and action bit 3 makes batDiscReq high, for the one cycle after the firing edge.
- R10: A channel whose selection mask is all zero never fires.
- R11: After reset, status is 0, irq is 0, ecRstN is 1, and sysRstReq and batDiscReq are 0.
- R12: Each channel uses only its own selection, threshold and action fields. A press that completes one channel's combination does not affect another channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnIn | input | NIN | Active-low inputs: bit 0 power button, bits 1..3 keys |
| selMask | input | NCH*NIN | Per-channel selection mask, channel i at bits [i*NIN +: NIN] |
| holdTicks | input | NCH*TW | Per-channel hold threshold in ticks |
| actMask | input | NCH*4 | Per-channel actions: bit0 irq, bit1 reset pulse, bit2 local reset, bit3 battery disconnect |
| pulseWidth | input | PWW | Reset pulse width in cycles |
| statusClr | input | NCH | Per-channel status clear strobe |
| irq | output | 1 | OR of all status bits |
| status | output | NCH | Sticky per-channel interrupt status |
| ecRstN | output | 1 | Active-low external controller reset pulse |
| sysRstReq | output | 1 | One-cycle local reset request |
| batDiscReq | output | 1 | One-cycle battery disconnect request |

## Verification
Call t0 the first clock edge that sees a combination pressed. The status bit, sysRstReq and batDiscReq change on edge t0+H. ecRstN goes low on that same edge and comes back high on edge t0+H+pulseWidth. irq follows a status bit with no added delay. A status clear takes effect on the edge after the strobe is driven. The bench drives inputs and samples outputs on falling edges. Its reference model advances on each rising edge, so every expected value is compared half a cycle after the edge that is meant to produce it. The directed cases count edges explicitly from the falling edge on which the press is driven.

// File: rtl/combo_pkg.sv
`timescale 1ns/1ps
package combo_pkg;
  localparam int NUM_ACT    = 4;
  localparam int ACT_IRQ    = 0;
  localparam int ACT_ECRST  = 1;
  localparam int ACT_SYSRST = 2;
  localparam int ACT_BATDIS = 3;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic fire;
  } ctrlStrb_t;

  typedef struct packed {
    logic allLow;
    logic fall;
    logic reached;
  } dpFlag_t;

  typedef enum logic {ST_IDLE, ST_TIMING} chanState_e;
endpackage

// File: rtl/combo_chan_dp.sv
`timescale 1ns/1ps
module combo_chan_dp
  import combo_pkg::*;
#(
  parameter int NIN = 4,
  parameter int TW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NIN-1:0] btnIn,
  input  logic [NIN-1:0] selMask,
  input  logic [TW-1:0]  holdTicks,
  input  ctrlStrb_t      strb,
  output dpFlag_t        flags
);
  logic          prevLow;
  logic [TW-1:0] holdCnt;
  logic          allLow;

  // pressed: at least one input selected and every selected input low
  assign allLow = (|selMask) && ((btnIn & selMask) == '0);

  // reset value 1 so that a press held through reset is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLow <= 1'b1;
    else       prevLow <= allLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdCnt <= '0;
    else if (strb.cntClr) holdCnt <= '0;
    else if (strb.cntInc) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    flags.allLow  = allLow;
    flags.fall    = allLow && !prevLow;
    flags.reached = ({1'b0, holdCnt} + {{TW{1'b0}}, 1'b1}) >= {1'b0, holdTicks};
  end

  // R3: counting only advances while the combination is pressed
  p_inc_while_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntInc |-> allLow);

  // R3: the counter restarts from zero after a clear strobe
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (holdCnt == '0));
endmodule

// File: rtl/combo_chan_ctrl.sv
`timescale 1ns/1ps
module combo_chan_ctrl
  import combo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpFlag_t   flags,
  output ctrlStrb_t strb
);
  chanState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (flags.fall) begin
          stateNxt    = ST_TIMING;
          strb.cntClr = 1'b1;
        end
      end
      ST_TIMING: begin
        if (!flags.allLow) begin
          stateNxt    = ST_IDLE;
          strb.cntClr = 1'b1;
        end else if (flags.reached) begin
          stateNxt    = ST_IDLE;
          strb.cntClr = 1'b1;
          strb.fire   = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R4: a fire is never followed by another on the next cycle
  p_fire_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> !strb.fire);

  // R3: firing requires the combination to be pressed
  p_fire_pressed_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> flags.allLow);
endmodule

// File: rtl/combo_rst_pulse.sv
`timescale 1ns/1ps
module combo_rst_pulse #(
  parameter int PWW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           load,
  input  logic [PWW-1:0] width,
  output logic           rstOutN
);
  logic [PWW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remain <= '0;
    else if (load)          remain <= width;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign rstOutN = (remain == '0);

  // R8: the pulse counts down one per cycle unless reloaded
  p_pulse_countdown_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

  // R8: a load of a nonzero width drives the output low on the next cycle
  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (load && width != '0) |=> !rstOutN);
endmodule

// File: rtl/combo_hold_det.sv
`timescale 1ns/1ps
module combo_hold_det
  import combo_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NIN = 4,
  parameter int TW  = 32,
  parameter int PWW = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NIN-1:0]         btnIn,
  input  logic [NCH*NIN-1:0]     selMask,
  input  logic [NCH*TW-1:0]      holdTicks,
  input  logic [NCH*NUM_ACT-1:0] actMask,
  input  logic [PWW-1:0]         pulseWidth,
  input  logic [NCH-1:0]         statusClr,
  output logic                   irq,
  output logic [NCH-1:0]         status,
  output logic                   ecRstN,
  output logic                   sysRstReq,
  output logic                   batDiscReq
);
  logic [NCH-1:0] fireVec, fireIrq, fireEc, fireSys, fireBat;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    ctrlStrb_t strb;
    dpFlag_t   flags;

    combo_chan_dp #(.NIN(NIN), .TW(TW)) dp_i (
      .clk      (clk),
      .rstN     (rstN),
      .btnIn    (btnIn),
      .selMask  (selMask[i*NIN +: NIN]),
      .holdTicks(holdTicks[i*TW +: TW]),
      .strb     (strb),
      .flags    (flags)
    );

    combo_chan_ctrl ctrl_i (
      .clk  (clk),
      .rstN (rstN),
      .flags(flags),
      .strb (strb)
    );

    assign fireVec[i] = strb.fire;
    assign fireIrq[i] = strb.fire && actMask[i*NUM_ACT + ACT_IRQ];
    assign fireEc[i]  = strb.fire && actMask[i*NUM_ACT + ACT_ECRST];
    assign fireSys[i] = strb.fire && actMask[i*NUM_ACT + ACT_SYSRST];
    assign fireBat[i] = strb.fire && actMask[i*NUM_ACT + ACT_BATDIS];

    // R10: an empty selection mask never fires
    p_empty_no_fire_r10: assert property (@(posedge clk) disable iff (!rstN)
      (selMask[i*NIN +: NIN] == '0) |-> !fireVec[i]);

    // R5: a status bit stays set unless cleared
    p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !statusClr[i]) |=> status[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status     <= '0;
      sysRstReq  <= 1'b0;
      batDiscReq <= 1'b0;
    end else begin
      status     <= (status & ~statusClr) | fireIrq;
      sysRstReq  <= |fireSys;
      batDiscReq <= |fireBat;
    end
  end

  assign irq = |status;

  combo_rst_pulse #(.PWW(PWW)) pulse_i (
    .clk    (clk),
    .rstN   (rstN),
    .load   (|fireEc),
    .width  (pulseWidth),
    .rstOutN(ecRstN)
  );

  // R7: the interrupt line only rises after an interrupt-enabled fire
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|fireIrq));

  // R9: a local reset request only follows a fire with that action enabled
  p_sysreq_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(|fireSys));
endmodule

// File: tb/combo_hold_det_tb.sv
`timescale 1ns/1ps
module combo_hold_det_tb_top;
  localparam int NCH = 4;
  localparam int NIN = 4;
  localparam int TW  = 32;
  localparam int PWW = 16;
  localparam int NA  = 4;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic [NIN-1:0]       btnIn;
  logic [NCH*NIN-1:0]   selMask;
  logic [NCH*TW-1:0]    holdTicks;
  logic [NCH*NA-1:0]    actMask;
  logic [PWW-1:0]       pulseWidth;
  logic [NCH-1:0]       statusClr;
  logic                 irq, ecRstN, sysRstReq, batDiscReq;
  logic [NCH-1:0]       status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  combo_hold_det #(.NCH(NCH), .NIN(NIN), .TW(TW), .PWW(PWW)) dut_i (
    .clk(clk), .rstN(rstN), .btnIn(btnIn), .selMask(selMask),
    .holdTicks(holdTicks), .actMask(actMask), .pulseWidth(pulseWidth),
    .statusClr(statusClr), .irq(irq), .status(status), .ecRstN(ecRstN),
    .sysRstReq(sysRstReq), .batDiscReq(batDiscReq)
  );

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic setChan(int i, logic [NIN-1:0] s, logic [TW-1:0] h, logic [NA-1:0] a);
    selMask[i*NIN +: NIN] = s;
    holdTicks[i*TW +: TW] = h;
    actMask[i*NA +: NA]   = a;
  endtask

  // reference model built from the requirements
  function automatic bit pressed(int i);
    logic [NIN-1:0] s;
    s = selMask[i*NIN +: NIN];
    return (s != '0) && ((btnIn & s) == '0);
  endfunction

  bit              mPrev[NCH];
  bit              mTim[NCH];
  int unsigned     mCnt[NCH];
  logic [NCH-1:0]  mStat;
  bit              mSys, mBat;
  int unsigned     mPulse;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        mPrev[i] = 1; mTim[i] = 0; mCnt[i] = 0;
      end
      mStat = '0; mSys = 0; mBat = 0; mPulse = 0;
    end else begin
      logic [NCH-1:0] f;
      bit anyEc, anySys, anyBat;
      f = '0; anyEc = 0; anySys = 0; anyBat = 0;
      for (int i = 0; i < NCH; i++) begin
        bit low;
        longint unsigned h;
        low = pressed(i);
        h = holdTicks[i*TW +: TW];
        if (h == 0) h = 1;
        if (!mTim[i]) begin
          if (low && !mPrev[i]) begin mTim[i] = 1; mCnt[i] = 0; end
        end else if (!low) begin
          mTim[i] = 0;
        end else if (longint'(mCnt[i]) + 1 >= h) begin
          f[i] = 1; mTim[i] = 0;
        end else begin
          mCnt[i]++;
        end
        mPrev[i] = low;
        if (f[i]) begin
          if (actMask[i*NA + 0]) ; // status handled below
          anyEc  |= actMask[i*NA + 1];
          anySys |= actMask[i*NA + 2];
          anyBat |= actMask[i*NA + 3];
        end
      end
      for (int i = 0; i < NCH; i++)
        mStat[i] = (mStat[i] && !statusClr[i]) || (f[i] && actMask[i*NA + 0]);
      mSys = anySys;
      mBat = anyBat;
      if (anyEc) mPulse = pulseWidth;
      else if (mPulse > 0) mPulse--;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R5 status", status, mStat);
      chk("R7 irq", irq, |mStat);
      chk("R8 ecRstN", ecRstN, mPulse == 0);
      chk("R9 sysRstReq", sysRstReq, mSys);
      chk("R9 batDiscReq", batDiscReq, mBat);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 0; btnIn = '0; statusClr = '0; selMask = '0; holdTicks = '0;
    actMask = '0; pulseWidth = 3;
    setChan(0, 4'b0011, 5, 4'b1111);
    setChan(1, 4'b0000, 0, 4'b1111);
    repeat (3) @(negedge clk);
    chk("R11 status", status, 0);
    chk("R11 irq", irq, 0);
    chk("R11 ecRstN", ecRstN, 1);
    chk("R11 sysRstReq", sysRstReq, 0);
    chk("R11 batDiscReq", batDiscReq, 0);
    rstN = 1;
    repeat (20) @(negedge clk);
    chk("R2 held through reset", status, 0);

    // R1: bit 2 low and bit 3 high are unselected and do not matter
    btnIn = 4'hF; repeat (3) @(negedge clk);
    btnIn = 4'b1000;
    repeat (5) @(negedge clk);
    chk("R3 one edge early", status[0], 0);
    @(negedge clk);
    chk("R3 fire on H-th edge", status[0], 1);
    chk("R1 unselected ignored", irq, 1);
    chk("R9 sys pulse", sysRstReq, 1);
    chk("R9 bat pulse", batDiscReq, 1);
    chk("R8 pulse starts", ecRstN, 0);
    @(negedge clk);
    chk("R9 sys one cycle", sysRstReq, 0);
    @(negedge clk);
    chk("R8 pulse last cycle", ecRstN, 0);
    @(negedge clk);
    chk("R8 pulse ends", ecRstN, 1);
    statusClr = 4'b0001; @(negedge clk); statusClr = '0;
    chk("R6 clear", status[0], 0);
    repeat (20) @(negedge clk);
    chk("R4 no refire while held", status[0], 0);

    // R3 release before threshold
    btnIn = 4'hF; repeat (2) @(negedge clk);
    btnIn = 4'b1100; repeat (3) @(negedge clk);
    btnIn = 4'b1101; @(negedge clk);
    btnIn = 4'b1100; repeat (5) @(negedge clk);
    chk("R3 restart count", status[0], 0);
    @(negedge clk);
    chk("R3 fire after restart", status[0], 1);

    // R3 hold of zero behaves as one
    btnIn = 4'hF; statusClr = 4'b0001; setChan(0, 4'b0011, 0, 4'b0001);
    @(negedge clk); statusClr = '0; @(negedge clk);
    btnIn = 4'b1100; @(negedge clk);
    chk("R3 hold0 first edge", status[0], 0);
    @(negedge clk);
    chk("R3 hold0 fires", status[0], 1);

    // R12 independent channel
    btnIn = 4'hF; statusClr = 4'hF; setChan(2, 4'b0100, 2, 4'b0001);
    @(negedge clk); statusClr = '0; @(negedge clk);
    btnIn = 4'b1011; repeat (3) @(negedge clk);
    chk("R12 only channel 2", status, 4'b0100);
    chk("R12 no pulse", ecRstN, 1);

    // R8 zero width gives no pulse
    pulseWidth = 0; setChan(3, 4'b1000, 1, 4'b0010);
    btnIn = 4'hF; repeat (2) @(negedge clk);
    btnIn = 4'b0111; repeat (3) @(negedge clk);
    chk("R8 zero width", ecRstN, 1);

    // R10 empty mask with all actions enabled
    btnIn = 4'h0; repeat (10) @(negedge clk);
    chk("R10 empty mask", status[1], 0);

    // random phase
    for (int blk = 0; blk < 6; blk++) begin
      for (int i = 0; i < NCH; i++)
        setChan(i, 4'($urandom), $urandom_range(0, 12), 4'($urandom));
      pulseWidth = PWW'($urandom_range(0, 6));
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        if ($urandom_range(0, 5) == 0) begin
          case ($urandom_range(0, 2))
            0: btnIn = 4'hF;
            1: btnIn = 4'h0;
            default: btnIn = 4'($urandom);
          endcase
        end
        statusClr = ($urandom_range(0, 15) == 0) ? 4'($urandom) : '0;
      end
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule